// File: doc/BRIEF.md
# Supervisory Reset Generator with Stretch

This block produces the system reset for a chip region from three kinds of events. The first is a synchronous supply-good level. The second is a pair of external reset pins, one asserted high and one asserted low. The third is a single-cycle watchdog expiry strobe. While supply-good is low, both reset outputs are held asserted. When supply-good comes up, a down-counter keeps them asserted for a parameterised number of clock cycles. The default of that parameter gives roughly 200 ms at 25 MHz.

The external pins are edge-sensitive rather than level-sensitive. Each passes through a two-flop synchronizer, and only its own asserting transition restarts the stretch counter at its full value. A bouncing button or a short pulse therefore turns into one clean reset of known length. A pin that is held in its asserted level does not keep the reset active. The watchdog strobe reloads the same counter. The two outputs are always exact complements of each other.

Top module: `rst_supervisor`

## Requirements
- R1: While `supply_ok` is 0, `sys_rst` is 1 and `sys_rst_n` is 0, independent of all other inputs.
- R2: After `supply_ok` goes from 0 to 1, `sys_rst` stays 1 through the first STRETCH_CYCLES-1 rising clock edges and is 0 after the STRETCH_CYCLES-th edge.
- R3: When `supply_ok` falls, `sys_rst` becomes 1 in the same cycle, without waiting for a clock edge.
- R4: A 0-to-1 transition on `ext_rst` makes `sys_rst` 1 after the third rising edge following it, and keeps it 1 for STRETCH_CYCLES cycles. Holding `ext_rst` at 1 after that, or its 1-to-0 transition, does not assert `sys_rst`.
- R5: A 1-to-0 transition on `ext_rst_n` makes `sys_rst` 1 after the third rising edge following it, and keeps it 1 for STRETCH_CYCLES cycles. Holding `ext_rst_n` at 0 after that, or its 0-to-1 transition, does not assert `sys_rst`.
- R6: `sys_rst_n` is always the complement of `sys_rst`.
- R7: A new trigger during an active stretch reloads the full count, so `sys_rst` stays 1 for STRETCH_CYCLES cycles counted from the new trigger.
- R8: `wdt_expire` sampled 1 at a rising edge makes `sys_rst` 1 after that edge, released after STRETCH_CYCLES edges in total.
- R9: While `arst_n` is 0, `sys_rst` is 1, and the stretch count is loaded to its full value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous initialisation, active low |
| supply_ok | input | 1 | Synchronous supply-good level |
| ext_rst | input | 1 | External reset pin, asserting edge is rising |
| ext_rst_n | input | 1 | External reset pin, asserting edge is falling |
| wdt_expire | input | 1 | Watchdog expiry strobe, synchronous |
| sys_rst | output | 1 | System reset, active high |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
A wrong count value shows at the ports as a release that comes early or late. The bench measures the release to the exact edge, so an off-by-one in the load value or the decrement shows up within one stretch period. A broken synchronizer or edge detector moves the assertion away from the third edge, or lets a held level or the opposite transition keep the reset asserted. That is visible within three cycles of the stimulus. A missing reload on retrigger shows as a release too early, measured from the second trigger.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  // Counter width needed to hold the full stretch value.
  function automatic int cnt_width(int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rsg_sync.sv
module rsg_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        meta <= INIT[i];
        stab <= INIT[i];
      end else begin
        meta <= d[i];
        stab <= meta;
      end
    end
    assign q[i] = stab;
  end
endmodule

// File: rtl/rsg_edge.sv
module rsg_edge #(
  parameter int W = 2,
  parameter logic [W-1:0] INIT = '0,
  parameter logic [W-1:0] RISE = '1
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] hit
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic prev;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) prev <= INIT[i];
      else         prev <= lvl[i];
    end
    if (RISE[i]) begin : g_rise
      assign hit[i] = lvl[i] & ~prev;
    end else begin : g_fall
      assign hit[i] = ~lvl[i] & prev;
    end
  end
endmodule

// File: rtl/rsg_timer.sv
module rsg_timer #(
  parameter int STRETCH_CYCLES = 5_000_000,
  parameter int CW = rsg_pkg::cnt_width(STRETCH_CYCLES)
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          hold,
  input  logic          load,
  output logic [CW-1:0] count,
  output logic          busy
);
  localparam logic [CW-1:0] FULL = CW'(STRETCH_CYCLES);

  function automatic logic [CW-1:0] next_count(logic h, logic l, logic [CW-1:0] c);
    if (h || l)        return FULL;
    else if (c != '0)  return c - 1'b1;
    else               return '0;
  endfunction

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) count <= FULL;
    else         count <= next_count(hold, load, count);
  end

  assign busy = (count != '0);
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int STRETCH_CYCLES = 5_000_000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic supply_ok,
  input  logic ext_rst,
  input  logic ext_rst_n,
  input  logic wdt_expire,
  output logic sys_rst,
  output logic sys_rst_n
);
  localparam int CW = rsg_pkg::cnt_width(STRETCH_CYCLES);

  logic [1:0]    pins_sync;
  logic [1:0]    pin_hit;
  logic          trig;
  logic          supply_low;
  logic [CW-1:0] count;
  logic          busy;

  // bit0: active-high pin, bit1: active-low pin
  rsg_sync #(.W(2), .INIT(2'b10)) u_sync (
    .clk(clk), .arst_n(arst_n), .d({ext_rst_n, ext_rst}), .q(pins_sync)
  );

  rsg_edge #(.W(2), .INIT(2'b10), .RISE(2'b01)) u_edge (
    .clk(clk), .arst_n(arst_n), .lvl(pins_sync), .hit(pin_hit)
  );

  assign supply_low = ~supply_ok;
  assign trig       = |pin_hit | wdt_expire;

  rsg_timer #(.STRETCH_CYCLES(STRETCH_CYCLES), .CW(CW)) u_timer (
    .clk(clk), .arst_n(arst_n), .hold(supply_low), .load(trig),
    .count(count), .busy(busy)
  );

  assign sys_rst   = supply_low | busy;
  assign sys_rst_n = ~sys_rst;
endmodule

// File: rtl/rsg_checks.sv
module rsg_checks #(
  parameter int STRETCH_CYCLES = 5_000_000,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          arst_n,
  input logic          supply_ok,
  input logic          trig,
  input logic [1:0]    pin_hit,
  input logic [CW-1:0] count,
  input logic          sys_rst,
  input logic          sys_rst_n
);
  localparam logic [CW-1:0] FULL = CW'(STRETCH_CYCLES);

  AST_SUPPLY_LOW_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
    !supply_ok |-> sys_rst && !sys_rst_n); // R1
  AST_RELEASE_AT_ZERO: assert property (@(posedge clk) disable iff (!arst_n)
    (supply_ok && count == '0) |-> !sys_rst); // R2
  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!arst_n)
    (supply_ok && !trig && count != '0) |=> count == $past(count) - 1'b1); // R2
  AST_PIN_EDGE_PULSE: assert property (@(posedge clk) disable iff (!arst_n)
    pin_hit[0] |=> !pin_hit[0]); // R4
  AST_PINN_EDGE_PULSE: assert property (@(posedge clk) disable iff (!arst_n)
    pin_hit[1] |=> !pin_hit[1]); // R5
  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!arst_n)
    sys_rst != sys_rst_n); // R6
  AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!arst_n)
    trig |=> count == FULL && sys_rst); // R7
endmodule

bind rst_supervisor rsg_checks #(.STRETCH_CYCLES(STRETCH_CYCLES), .CW(CW)) u_chk (
  .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .trig(trig),
  .pin_hit(pin_hit), .count(count), .sys_rst(sys_rst), .sys_rst_n(sys_rst_n)
);

// File: tb/tb_rst_supervisor.sv
module tb_rst_supervisor;
  localparam int S = 20;

  logic clk = 0;
  logic arst_n = 0, supply_ok = 0, ext_rst = 0, ext_rst_n = 1, wdt_expire = 0;
  logic sys_rst, sys_rst_n;
  int vectors = 0, errors = 0;

  always #2 clk = ~clk;

  rst_supervisor #(.STRETCH_CYCLES(S)) dut (
    .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .ext_rst(ext_rst),
    .ext_rst_n(ext_rst_n), .wdt_expire(wdt_expire),
    .sys_rst(sys_rst), .sys_rst_n(sys_rst_n)
  );

  task automatic check(string req, logic exp);
    vectors++;
    if (sys_rst !== exp || sys_rst_n !== ~exp) begin
      errors++;
      $display("FAIL %s: sys_rst=%b sys_rst_n=%b expected sys_rst=%b", req, sys_rst, sys_rst_n, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Assumes sys_rst just asserted at a trigger edge; checks the release timing.
  task automatic check_stretch(string req, int already);
    cyc(S - 1 - already); check(req, 1'b1);
    cyc(1);               check(req, 1'b0);
  endtask

  task automatic t_reset;
    cyc(3); check("R9", 1'b1);
    arst_n = 1; cyc(4); check("R1", 1'b1);
    ext_rst = 1; cyc(5); check("R1", 1'b1);
    ext_rst = 0; cyc(4);
  endtask

  task automatic t_powerup;
    supply_ok = 1;
    cyc(1);     check("R2", 1'b1);
    cyc(S - 2); check("R2", 1'b1);
    cyc(1);     check("R2", 1'b0);
    cyc(10);    check("R2", 1'b0);
  endtask

  task automatic t_ext_high;
    ext_rst = 1;
    cyc(2); check("R4", 1'b0);
    cyc(1); check("R4", 1'b1);
    check_stretch("R4", 0);
    cyc(10); check("R4", 1'b0);  // held high: no retrigger
    ext_rst = 0;
    cyc(4);  check("R4", 1'b0);  // opposite edge: no effect
  endtask

  task automatic t_ext_low;
    ext_rst_n = 0;
    cyc(2); check("R5", 1'b0);
    cyc(1); check("R5", 1'b1);
    check_stretch("R5", 0);
    cyc(10); check("R5", 1'b0);
    ext_rst_n = 1;
    cyc(4);  check("R5", 1'b0);
  endtask

  task automatic t_wdt;
    wdt_expire = 1; cyc(1); wdt_expire = 0;
    check("R8", 1'b1);
    check_stretch("R8", 0);
  endtask

  task automatic t_retrigger;
    ext_rst = 1; cyc(3); check("R7", 1'b1);
    cyc(8); ext_rst = 0;
    wdt_expire = 1; cyc(1); wdt_expire = 0;
    check("R7", 1'b1);
    check_stretch("R7", 0);
    cyc(4);
  endtask

  task automatic t_powerdown;
    supply_ok = 0; #1;
    check("R3", 1'b1);
    cyc(3); check("R1", 1'b1);
    wdt_expire = 1; cyc(1); wdt_expire = 0; check("R1", 1'b1);
    supply_ok = 1; cyc(1);
    check_stretch("R2", 1);
  endtask

  initial begin
    cyc(1);
    t_reset();
    t_powerup();
    t_ext_high();
    t_ext_low();
    t_wdt();
    t_retrigger();
    t_powerdown();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #100000;
    vectors++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule